// File: doc/BRIEF.md
# Free-Running Timer with Overflow Flag

This block is a 16-bit up-counter that runs without stopping behind a selectable clock divider. Each time the count wraps from all ones back to zero it raises a sticky overflow flag. Software can poll that flag, or it can enable it onto an interrupt request line. Software clears the flag by writing a one to its bit position. Writing a zero to that bit leaves the flag alone.

A small byte-wide register port gives access to the block. It has a single-cycle write strobe and a combinational read path. Through it software reaches the interrupt enable register, the status flag register, the counter (as two bytes that read coherently) and a test control register. The test control register holds a bypass bit, which can only be changed while the special-mode input is high. With bypass set, the divider is skipped. Both bytes of the counter then advance on every clock, each on its own, with no carry between them. This lets a test reach the wrap point in a few hundred cycles.

The RTI and pulse-accumulator enable and flag bits take up their bit positions in the registers. They are storage only: nothing in the block sets those flags.

Top module: `ovf_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low. The registers are: enable at offset 0, flags at offset 1, counter high byte at offset 2, latched low byte at offset 3, test control at offset 4. The divider phase counter also starts at zero.
- R2: Enable bits 1:0 pick the divide ratio: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. Number the clock edges since reset release from 0. Outside bypass, the counter advances by one on each edge k where k mod ratio equals ratio-1. A new ratio takes effect on the edge after it is written.
- R3: On an edge where the counter advances from 0xFFFF, the counter becomes 0x0000 and flag bit 7 sets.
- R4: A write to offset 1 clears each flag bit whose written data bit is one. Flag bits written with zero keep their value. If the hardware sets a flag on the same edge as a clear write, the flag ends up set.
- R5: `irq` is high exactly when some enable bit among 7:4 and the flag bit at the same position are both one. Writing the enable bits never changes the flags.
- R6: The enable register is read/write at bits 7:4 and 1:0. Its bits 3:2 read as zero. Flag bits 3:0 always read as zero.
- R7: Reading offset 2 returns counter bits 15:8, and with `rd_en` high it captures counter bits 7:0 on that edge. Reading offset 3 returns the captured byte.
- R8: Bit 0 of offset 4 is the bypass control, and it reads back. A write to it takes effect only while `special_mode` is high. Otherwise the write is ignored.
- R9: While bypass is set, the divider is ignored, and both counter bytes step by one on every edge with no carry between them. The overflow flag sets on the edge where the value goes from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | High allows writes to the bypass bit |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, used for the low-byte capture |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench times a clear write to land on the very edge where the counter wraps. A design that lets the clear win would lose that overflow and read the flag as zero. It checks that a write of zero to the flag register keeps the flag set. It also checks that turning the enable off drops `irq` while the flag stays set; a design that tied the flag to its enable fails here. The bench lines the two counter bytes up so that bypass reaches 0xFFFF. A design that carried between the bytes, or that missed the wrap in bypass, would give the wrong reads and no flag. It also sends bypass writes with `special_mode` low; a design that accepted them would read back a one. Coherent high/low reads are checked under every divide ratio. A design that returned the live low byte would go wrong whenever the low byte moved between the two reads.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

   typedef enum logic [2:0] {
      REG_ENABLE = 3'd0,
      REG_FLAGS  = 3'd1,
      REG_CNT_HI = 3'd2,
      REG_CNT_LO = 3'd3,
      REG_TEST   = 3'd4
   } reg_sel_e;

   localparam int NUM_SRC   = 4;   // enable/flag pairs in bits 7:4
   localparam int SRC_LSB   = 4;
   localparam int OVF_IDX   = 3;   // overflow sits at bit 7
   localparam int PSEL_W    = 2;

   // mask of divider phase bits that must be all ones for a step
   function automatic logic [3:0] ratio_mask(input logic [PSEL_W-1:0] sel);
      case (sel)
         2'b00:   ratio_mask = 4'b0000;
         2'b01:   ratio_mask = 4'b0011;
         2'b10:   ratio_mask = 4'b0111;
         default: ratio_mask = 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/ovf_prescaler.sv
module ovf_prescaler
   import ovf_timer_pkg::*;
#(
   parameter int PRE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSEL_W-1:0] sel,
   output logic              tick
);

   if (PRE_W < 4) begin : g_bad_pre
      $error("ovf_prescaler: PRE_W must cover a divide by 16");
   end

   logic [PRE_W-1:0] phase_q;
   logic [PRE_W-1:0] need_ones;

   assign need_ones = PRE_W'(ratio_mask(sel));
   assign tick      = &(phase_q | ~need_ones);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= '0;
      else        phase_q <= phase_q + 1'b1;
   end

   // R2: the divider phase always moves forward
   a_r2_phase_runs: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_q == $past(phase_q) + 1'b1);

endmodule

// File: rtl/ovf_counter.sv
module ovf_counter #(
   parameter int CNT_W      = 16,
   parameter int SEG_W      = 8,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             bypass,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);

   localparam int NSEG = CNT_W / SEG_W;

   if (CNT_W % SEG_W != 0 || NSEG < 1) begin : g_bad_seg
      $error("ovf_counter: CNT_W must be a multiple of SEG_W");
   end

   logic            byp_eff;
   logic [NSEG:0]   chain;

   if (HAS_BYPASS) begin : g_byp
      assign byp_eff = bypass;
   end else begin : g_nobyp
      logic unused_byp;
      assign unused_byp = bypass;
      assign byp_eff    = 1'b0;
   end

   assign chain[0] = tick;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [SEG_W-1:0] seg_q;
      logic             step;

      assign step       = byp_eff | chain[s];
      assign chain[s+1] = chain[s] & (&seg_q);
      assign count[s*SEG_W +: SEG_W] = seg_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    seg_q <= '0;
         else if (step) seg_q <= seg_q + 1'b1;
      end
   end

   assign wrap = (byp_eff | tick) & (&count);

   // R3: a wrap leaves the counter at zero
   a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> count == '0);

   // R9: in bypass the lowest and highest bytes both step each clock
   a_r9_low_steps: assert property (@(posedge clk) disable iff (!rst_n)
      byp_eff |=> count[SEG_W-1:0] == $past(count[SEG_W-1:0]) + 1'b1);
   a_r9_high_steps: assert property (@(posedge clk) disable iff (!rst_n)
      byp_eff |=> count[CNT_W-1 -: SEG_W] == $past(count[CNT_W-1 -: SEG_W]) + 1'b1);

   // R2: without a step request and outside bypass the count holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !byp_eff) |=> $stable(count));

endmodule

// File: rtl/ovf_flag_reg.sv
module ovf_flag_reg #(
   parameter int NFLAG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] hw_set,
   input  logic             clr_wr,
   input  logic [NFLAG-1:0] clr_data,
   output logic [NFLAG-1:0] flags
);

   if (NFLAG < 1) begin : g_bad_nflag
      $error("ovf_flag_reg: NFLAG must be positive");
   end

   logic [NFLAG-1:0] clr_mask;
   assign clr_mask = clr_wr ? clr_data : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_mask) | hw_set;
   end

   // R4: a hardware set is never lost to a simultaneous clear
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> (flags & $past(hw_set)) == $past(hw_set));

   // R4: with no clear write, set flags stay set
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> (flags & $past(flags)) == $past(flags));

endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
   import ovf_timer_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int SEG_W      = 8,
   parameter int PRE_W      = 4,
   parameter int ADDR_W     = 3,
   parameter int DATA_W     = 8,
   parameter bit HAS_BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);

   localparam int HALF_W = CNT_W / 2;

   if (DATA_W != 8 || CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("ovf_timer: needs an 8-bit port and a 16-bit counter");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ovf_timer: ADDR_W must reach offset 4");
   end

   logic [NUM_SRC-1:0] en_q;
   logic [PSEL_W-1:0]  psel_q;
   logic               byp_q;
   logic [HALF_W-1:0]  lat_q;
   logic [NUM_SRC-1:0] flags;
   logic [CNT_W-1:0]   count;
   logic               tick, wrap;
   logic               sel_en, sel_flg, sel_hi, sel_test;
   logic               unused_wbits;

   assign unused_wbits = ^wdata[3:2];

   assign sel_en   = addr == ADDR_W'(REG_ENABLE);
   assign sel_flg  = addr == ADDR_W'(REG_FLAGS);
   assign sel_hi   = addr == ADDR_W'(REG_CNT_HI);
   assign sel_test = addr == ADDR_W'(REG_TEST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         psel_q <= '0;
      end else if (wr_en && sel_en) begin
         en_q   <= wdata[SRC_LSB +: NUM_SRC];
         psel_q <= wdata[PSEL_W-1:0];
      end
   end

   if (HAS_BYPASS) begin : g_test_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              byp_q <= 1'b0;
         else if (wr_en && sel_test && special_mode) byp_q <= wdata[0];
      end
   end else begin : g_no_test_reg
      assign byp_q = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lat_q <= '0;
      else if (rd_en && sel_hi) lat_q <= count[HALF_W-1:0];
   end

   ovf_prescaler #(.PRE_W(PRE_W)) i_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (psel_q),
      .tick (tick)
   );

   ovf_counter #(
      .CNT_W     (CNT_W),
      .SEG_W     (SEG_W),
      .HAS_BYPASS(HAS_BYPASS)
   ) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .bypass(byp_q),
      .count (count),
      .wrap  (wrap)
   );

   logic [NUM_SRC-1:0] hw_set;
   always_comb begin
      hw_set          = '0;
      hw_set[OVF_IDX] = wrap;
   end

   ovf_flag_reg #(.NFLAG(NUM_SRC)) i_flg (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (hw_set),
      .clr_wr  (wr_en && sel_flg),
      .clr_data(wdata[SRC_LSB +: NUM_SRC]),
      .flags   (flags)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(REG_ENABLE): rdata = {en_q, 2'b00, psel_q};
         ADDR_W'(REG_FLAGS):  rdata = {flags, 4'b0000};
         ADDR_W'(REG_CNT_HI): rdata = count[CNT_W-1:HALF_W];
         ADDR_W'(REG_CNT_LO): rdata = lat_q;
         ADDR_W'(REG_TEST):   rdata = {{(DATA_W-1){1'b0}}, byp_q};
         default:             rdata = '0;
      endcase
   end

   assign irq = |(en_q & flags);

   // R8: bypass control ignores writes outside special mode
   a_r8_test_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_test && !special_mode) |=> $stable(byp_q));

   // R5: an enabled overflow flag always raises the request
   a_r5_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[OVF_IDX] && flags[OVF_IDX]) |-> irq);

   // R5: enable writes leave the flags untouched
   a_r5_en_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel_en && !wrap) |=> $stable(flags));

   // R2: ratio 1 outside bypass steps on every edge
   a_r2_div1_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (psel_q == '0 && !byp_q) |=> count == $past(count) + 1'b1);

   // R3: an advance from all ones raises the overflow flag
   a_r3_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap) |=> flags[OVF_IDX]);

endmodule

// File: tb/test_ovf_timer.sv
module test_ovf_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;

   always #10 clk = ~clk;

   ovf_timer i_ovf_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .special_mode(special_mode),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wdata       (wdata),
      .rdata       (rdata),
      .irq         (irq)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural reference state
   int m_cnt = 0, m_mask = 0, m_flag = 0, m_byp = 0, m_lat = 0, cyc = 0;

   always @(posedge clk) begin
      int div, old;
      bit wrapv;
      if (!rst_n) begin
         m_cnt = 0; m_mask = 0; m_flag = 0; m_byp = 0; m_lat = 0; cyc = 0;
      end else begin
         div   = ((m_mask & 3) == 0) ? 1 : (2 << (m_mask & 3));
         old   = m_cnt;
         wrapv = 0;
         if (m_byp != 0) begin
            if (m_cnt == 65535) wrapv = 1;
            m_cnt = ((((m_cnt >> 8) + 1) & 255) << 8) | ((m_cnt + 1) & 255);
         end else if (cyc % div == div - 1) begin
            if (m_cnt == 65535) wrapv = 1;
            m_cnt = (m_cnt + 1) & 65535;
         end
         if (rd_en && addr == 3'd2) m_lat = old & 255;
         if (wr_en) begin
            case (addr)
               3'd0: m_mask = wdata & 8'hF3;
               3'd1: m_flag = m_flag & ~(wdata & 8'hF0);
               3'd4: if (special_mode) m_byp = wdata[0];
               default: ;
            endcase
         end
         if (wrapv) m_flag = m_flag | 8'h80;
         cyc++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_rd(input int a);
      case (a)
         0: return m_mask;
         1: return m_flag;
         2: return (m_cnt >> 8) & 255;
         3: return m_lat;
         4: return m_byp;
         default: return 0;
      endcase
   endfunction

   // R5: request compared with the model every cycle
   always @(negedge clk) begin
      if (!done) chk("R5 irq", int'(irq), int'((m_mask & m_flag & 8'hF0) != 0));
   end

   task automatic wr(input int a, input int d);
      addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, input string req);
      addr = 3'(a); rd_en = 1'b1;
      #2 chk(req, int'(rdata), exp_rd(a));
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL R3 watchdog expired: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset values
      chk("R1 irq", int'(irq), 0);
      for (int a = 0; a < 5; a++) rd(a, "R1");
      // R2 / R7 divide ratios and coherent reads
      for (int s = 0; s < 4; s++) begin
         wr(0, s);
         for (int k = 0; k < 6; k++) begin
            idle(3);
            rd(2, "R2 hi");
            rd(3, "R7 lo");
         end
      end
      // R6 layout
      wr(0, 8'hFF);
      rd(0, "R6 enable");
      rd(1, "R6 flags");
      wr(1, 8'hFF);
      rd(1, "R4 clear empty");
      // R3 normal wrap at ratio 1 with overflow enabled
      wr(0, 8'h80);
      while ((m_flag & 8'h80) == 0) @(negedge clk);
      rd(1, "R3 flag");
      rd(2, "R3 hi");
      wr(1, 8'h00);
      rd(1, "R4 zero keeps");
      wr(0, 8'h00);
      chk("R5 disabled", int'(irq), 0);
      rd(1, "R5 flag kept");
      wr(1, 8'h80);
      rd(1, "R4 cleared");
      // R8 locked outside special mode
      wr(4, 1);
      rd(4, "R8 locked");
      // R9 bypass from aligned bytes
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      wr(0, 8'h80);
      while (m_cnt != 16'h0302) @(negedge clk);
      special_mode = 1'b1;
      wr(4, 1);
      rd(4, "R8 special");
      for (int k = 0; k < 4; k++) begin
         rd(2, "R9 hi");
         rd(3, "R9 lo");
      end
      while (m_cnt != 16'hFFFF) @(negedge clk);
      wr(1, 8'h80);
      rd(1, "R4 set wins");
      chk("R5 bypass irq", int'(irq), 1);
      wr(1, 8'h80);
      rd(1, "R4 clear");
      while ((m_flag & 8'h80) == 0) @(negedge clk);
      rd(1, "R9 wrap");
      rd(2, "R9 hi after wrap");
      special_mode = 1'b0;
      wr(4, 0);
      rd(4, "R8 kept");
      done = 1;
      summary();
      $finish;
   end

endmodule